// File: doc/BRIEF.md
# Page Cache DMA Transfer Engine

This block moves one NAND cache page between system memory and a serial NAND device. The serial side is modelled as a byte stream. A read-from-cache transfer takes bytes from the device, packs them into 32-bit words and writes them to consecutive memory words. A program-load transfer fetches words from memory and sends their bytes to the device, lowest byte first. Each transfer opens with a one-cycle command pulse. The pulse carries the opcode, the lane mode and the byte count for the serial engine.

Software sets up the start address, the byte count, the opcode, the lane mode and the operation mode through a small word-indexed register port. It then starts the transfer by raising a trigger bit. Read and write each have their own trigger. When the transfer ends, the block sets a sticky done bit for its direction and a shared memory-done flag. The memory-done flag drives an interrupt line when its enable bit is set. All of these flags are cleared by writing 1 to them.

Top module: `page_cache_dma`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, and `memValid`, `devRxReady`, `devTxValid` and `devStart` are low. Register word indices are: 0 config, 1 control, 2 interrupt enable, 3 interrupt status, 4 start address, 5 byte counts, 6 lane select, 7 read opcode, 8 load opcode, 9 done status.
- R2: A transfer starts only when the engine is idle, on a 0-to-1 change of control bit 8 (read) or bit 9 (write). Config bit 0 (DMA enable) must be 1. Config bit 1 must be 1 for a read and 0 for a write. Config bits 14:12 must hold 6 for a read or 3 for a write. Any other trigger edge starts nothing.
- R3: A start gives a one-cycle `devStart` pulse with a direction flag, an opcode and a byte count. A read takes its opcode from read-opcode bits 7:0 and its count from count-register bits 12:0. A write takes its opcode from load-opcode bits 15:8 and its count from count-register bits 28:16.
- R4: `devLanes` is coded 0 single, 1 dual, 2 quad. The lane field is bits 18:16 of the lane register. For a read, field 1 gives dual, field 2 gives quad and any other value gives single. For a write, field 2 gives quad and any other value gives single.
- R5: A read packs device bytes little-endian into words. The words are written to consecutive addresses starting at the start address with its two low bits cleared. The last word is zero-filled above the final byte, and nothing is written past it.
- R6: A write fetches words from consecutive addresses starting at the start address with its two low bits cleared. It sends exactly the programmed number of bytes, lowest byte of each word first.
- R7: Once `memValid` is raised, it stays high with `memAddr`, `memWdata` and `memWe` stable until `memReady` is seen.
- R8: At the end of a read, status bit 25 sets. At the end of a write, status bit 26 sets. Either end also sets interrupt-status bit 6. On a read these flags rise only after the last memory write has been accepted.
- R9: Writing 1 to status bit 25, status bit 26 or interrupt-status bit 6 clears that bit. Writing 0 leaves it unchanged.
- R10: `irq` is high exactly when interrupt-status bit 6 and interrupt-enable bit 6 are both set.
- R11: A trigger edge that arrives while a transfer runs is ignored. A trigger bit left at 1 after completion does not start another transfer.
- R12: Writing 1 to control bit 0 (flush) or bit 1 (engine reset) returns the engine to idle at once. No done flag is set. These two bits always read back 0.
- R13: A byte count of zero still issues the command pulse. The done flags are then set without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Memory-done interrupt |
| memValid | output | 1 | Memory request valid |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory word address (byte address, word-aligned) |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memReady |
| memReady | input | 1 | Memory accepts the request |
| devStart | output | 1 | One-cycle command pulse to the serial engine |
| devRead | output | 1 | Command direction, 1 for read-from-cache |
| devOpcode | output | 8 | Command opcode |
| devLanes | output | 2 | Lane mode: 0 single, 1 dual, 2 quad |
| devCount | output | 13 | Command byte count |
| devRxValid | input | 1 | Device byte available |
| devRxData | input | 8 | Device byte |
| devRxReady | output | 1 | Engine accepts a device byte |
| devTxValid | output | 1 | Engine offers a byte to the device |
| devTxData | output | 8 | Byte to the device |
| devTxReady | input | 1 | Device accepts the byte |

## Verification
The hardest state to reach from the ports is a transfer in flight when a second trigger edge or an engine-reset write arrives. A short transfer normally finishes within a few cycles. To hold it open, the bench's device model can stop offering bytes on command. This parks the engine in its receive state while the bench writes the control register, after which the bench releases the stream. Memory and device readiness follow stall patterns that do not line up with word boundaries, so the handshake hold and the partial final word both occur.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] OFF_CFG    = 4'd0;
  localparam logic [REG_AW-1:0] OFF_CTRL   = 4'd1;
  localparam logic [REG_AW-1:0] OFF_INTEN  = 4'd2;
  localparam logic [REG_AW-1:0] OFF_INTST  = 4'd3;
  localparam logic [REG_AW-1:0] OFF_START  = 4'd4;
  localparam logic [REG_AW-1:0] OFF_COUNT  = 4'd5;
  localparam logic [REG_AW-1:0] OFF_LANE   = 4'd6;
  localparam logic [REG_AW-1:0] OFF_RDOP   = 4'd7;
  localparam logic [REG_AW-1:0] OFF_PGOP   = 4'd8;
  localparam logic [REG_AW-1:0] OFF_STATUS = 4'd9;

  localparam logic [2:0] MODE_CACHE_RD = 3'd6;
  localparam logic [2:0] MODE_PG_LOAD  = 3'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_RX, S_MWR, S_MRD, S_TX, S_FIN
  } pcdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture start address and count
    logic takeRx;    // pack one device byte
    logic takeTx;    // one byte went to the device
    logic wordDone;  // memory write accepted
    logic loadWord;  // memory read data captured
  } pcdStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic wordEnd;   // current byte closes the word or the transfer
    logic lastByte;  // exactly one byte remains
    logic noneLeft;  // no bytes remain
  } pcdFlags_t;
endpackage

// File: rtl/pcd_datapath.sv
module pcd_datapath
  import pcd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcdStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  xferCount,
  input  logic [7:0]        devRxData,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [7:0]        devTxData,
  output pcdFlags_t         flags
);
  localparam int BYTES  = WORD_W / 8;
  localparam int SLOT_W = $clog2(BYTES);
  localparam int LOW_W  = SLOT_W;

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  remainQ;
  logic [SLOT_W-1:0] slotQ;
  logic [WORD_W-1:0] wordQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      remainQ <= '0;
      slotQ   <= '0;
      wordQ   <= '0;
    end else if (strobe.load) begin
      addrQ   <= {startAddr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
      remainQ <= xferCount;
      slotQ   <= '0;
      wordQ   <= '0;
    end else begin
      if (strobe.takeRx) begin
        wordQ[{slotQ, 3'b000} +: 8] <= devRxData;
        remainQ <= remainQ - 1'b1;
        slotQ   <= slotQ + 1'b1;
      end
      if (strobe.takeTx) begin
        remainQ <= remainQ - 1'b1;
        slotQ   <= slotQ + 1'b1;
      end
      if (strobe.wordDone) begin
        addrQ <= addrQ + ADDR_W'(BYTES);
        wordQ <= '0;
        slotQ <= '0;
      end
      if (strobe.loadWord) begin
        addrQ <= addrQ + ADDR_W'(BYTES);
        wordQ <= memRdata;
        slotQ <= '0;
      end
    end
  end

  assign memAddr        = addrQ;
  assign memWdata       = wordQ;
  assign devTxData      = wordQ[{slotQ, 3'b000} +: 8];
  assign flags.lastByte = (remainQ == CNT_W'(1));
  assign flags.noneLeft = (remainQ == '0);
  assign flags.wordEnd  = (slotQ == SLOT_W'(BYTES - 1)) || (remainQ == CNT_W'(1));

  // R5 R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remainQ == '0) |-> !(strobe.takeRx || strobe.takeTx));
endmodule

// File: rtl/pcd_ctrl.sv
module pcd_ctrl
  import pcd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  input  pcdFlags_t         flags,
  output pcdStrobe_t        strobe,
  output logic [ADDR_W-1:0] startAddr,
  output logic [CNT_W-1:0]  xferCount,
  output logic              memValid,
  output logic              memWe,
  input  logic              memReady,
  output logic              devStart,
  output logic              devRead,
  output logic [7:0]        devOpcode,
  output logic [1:0]        devLanes,
  output logic [CNT_W-1:0]  devCount,
  input  logic              devRxValid,
  output logic              devRxReady,
  output logic              devTxValid,
  input  logic              devTxReady
);
  localparam int WR_CNT_LSB = 16;

  logic              cfgDma, cfgRead;
  logic [2:0]        cfgMode;
  logic              rdTrig, wrTrig, rdTrigQ, wrTrigQ;
  logic              intEn, memDone, rdDone, wrDone;
  logic [ADDR_W-1:0] startQ;
  logic [CNT_W-1:0]  rdCount, wrCount;
  logic [2:0]        laneSel;
  logic [7:0]        rdOp, pgOp;
  pcdState_e         state, stateNext;
  logic              dirRead;
  logic              rdGo, wrGo, abort;

  assign abort = regWe && (regAddr == OFF_CTRL) && (regWdata[0] || regWdata[1]);
  assign rdGo  = (state == S_IDLE) && rdTrig && !rdTrigQ && cfgDma && cfgRead
                 && (cfgMode == MODE_CACHE_RD);
  assign wrGo  = (state == S_IDLE) && wrTrig && !wrTrigQ && cfgDma && !cfgRead
                 && (cfgMode == MODE_PG_LOAD);

  // register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgDma <= 1'b0; cfgRead <= 1'b0; cfgMode <= '0;
      rdTrig <= 1'b0; wrTrig <= 1'b0; rdTrigQ <= 1'b0; wrTrigQ <= 1'b0;
      intEn <= 1'b0; memDone <= 1'b0; rdDone <= 1'b0; wrDone <= 1'b0;
      startQ <= '0; rdCount <= '0; wrCount <= '0;
      laneSel <= '0; rdOp <= '0; pgOp <= '0;
    end else begin
      rdTrigQ <= rdTrig;
      wrTrigQ <= wrTrig;
      if (regWe) begin
        case (regAddr)
          OFF_CFG: begin
            cfgDma  <= regWdata[0];
            cfgRead <= regWdata[1];
            cfgMode <= regWdata[14:12];
          end
          OFF_CTRL: begin
            rdTrig <= regWdata[8];
            wrTrig <= regWdata[9];
          end
          OFF_INTEN: intEn <= regWdata[6];
          OFF_INTST: if (regWdata[6]) memDone <= 1'b0;
          OFF_START: startQ <= regWdata[ADDR_W-1:0];
          OFF_COUNT: begin
            rdCount <= regWdata[CNT_W-1:0];
            wrCount <= regWdata[WR_CNT_LSB +: CNT_W];
          end
          OFF_LANE: laneSel <= regWdata[18:16];
          OFF_RDOP: rdOp <= regWdata[7:0];
          OFF_PGOP: pgOp <= regWdata[15:8];
          OFF_STATUS: begin
            if (regWdata[25]) rdDone <= 1'b0;
            if (regWdata[26]) wrDone <= 1'b0;
          end
          default: ;
        endcase
      end
      // completion sets win over a clear in the same cycle
      if (state == S_FIN) begin
        memDone <= 1'b1;
        if (dirRead) rdDone <= 1'b1;
        else         wrDone <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFF_CFG:    begin regRdata[0] = cfgDma; regRdata[1] = cfgRead; regRdata[14:12] = cfgMode; end
      OFF_CTRL:   begin regRdata[8] = rdTrig; regRdata[9] = wrTrig; end
      OFF_INTEN:  regRdata[6] = intEn;
      OFF_INTST:  regRdata[6] = memDone;
      OFF_START:  regRdata[ADDR_W-1:0] = startQ;
      OFF_COUNT:  begin regRdata[CNT_W-1:0] = rdCount; regRdata[WR_CNT_LSB +: CNT_W] = wrCount; end
      OFF_LANE:   regRdata[18:16] = laneSel;
      OFF_RDOP:   regRdata[7:0] = rdOp;
      OFF_PGOP:   regRdata[15:8] = pgOp;
      OFF_STATUS: begin regRdata[25] = rdDone; regRdata[26] = wrDone; end
      default:    regRdata = '0;
    endcase
  end

  assign irq = memDone && intEn;

  // command fields
  assign xferCount = dirRead ? rdCount : wrCount;
  assign devCount  = xferCount;
  assign devRead   = dirRead;
  assign devOpcode = dirRead ? rdOp : pgOp;
  assign startAddr = startQ;

  always_comb begin
    if (dirRead) begin
      case (laneSel)
        3'd1:    devLanes = 2'd1;
        3'd2:    devLanes = 2'd2;
        default: devLanes = 2'd0;
      endcase
    end else begin
      devLanes = (laneSel == 3'd2) ? 2'd2 : 2'd0;
    end
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      dirRead <= 1'b0;
    end else if (abort) begin
      state <= S_IDLE;
    end else begin
      state <= stateNext;
      if (rdGo)      dirRead <= 1'b1;
      else if (wrGo) dirRead <= 1'b0;
    end
  end

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    memValid   = 1'b0;
    memWe      = 1'b0;
    devStart   = 1'b0;
    devRxReady = 1'b0;
    devTxValid = 1'b0;
    case (state)
      S_IDLE: if (rdGo || wrGo) stateNext = S_CMD;
      S_CMD: begin
        devStart    = 1'b1;
        strobe.load = 1'b1;
        if (xferCount == '0) stateNext = S_FIN;
        else                 stateNext = dirRead ? S_RX : S_MRD;
      end
      S_RX: begin
        devRxReady = 1'b1;
        if (devRxValid) begin
          strobe.takeRx = 1'b1;
          if (flags.wordEnd) stateNext = S_MWR;
        end
      end
      S_MWR: begin
        memValid = 1'b1;
        memWe    = 1'b1;
        if (memReady) begin
          strobe.wordDone = 1'b1;
          stateNext = flags.noneLeft ? S_FIN : S_RX;
        end
      end
      S_MRD: begin
        memValid = 1'b1;
        if (memReady) begin
          strobe.loadWord = 1'b1;
          stateNext = S_TX;
        end
      end
      S_TX: begin
        devTxValid = 1'b1;
        if (devTxReady) begin
          strobe.takeTx = 1'b1;
          if (flags.wordEnd) stateNext = flags.lastByte ? S_FIN : S_MRD;
        end
      end
      S_FIN:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    devStart |-> $past(cfgDma));
  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    devStart |=> !devStart);
  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady && !abort) |=> (memValid && $stable(memWe)));
  // R5 R6
  one_side_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memValid, devRxReady, devTxValid}));
  // R8
  done_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdDone) || $rose(wrDone)) |-> memDone);
endmodule

// File: rtl/page_cache_dma.sv
module page_cache_dma
  import pcd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  output logic              memValid,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memReady,
  output logic              devStart,
  output logic              devRead,
  output logic [7:0]        devOpcode,
  output logic [1:0]        devLanes,
  output logic [CNT_W-1:0]  devCount,
  input  logic              devRxValid,
  input  logic [7:0]        devRxData,
  output logic              devRxReady,
  output logic              devTxValid,
  output logic [7:0]        devTxData,
  input  logic              devTxReady
);
  pcdStrobe_t        strobe;
  pcdFlags_t         flags;
  logic [ADDR_W-1:0] startAddr;
  logic [CNT_W-1:0]  xferCount;

  pcd_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irq(irq), .flags(flags), .strobe(strobe),
    .startAddr(startAddr), .xferCount(xferCount),
    .memValid(memValid), .memWe(memWe), .memReady(memReady),
    .devStart(devStart), .devRead(devRead), .devOpcode(devOpcode),
    .devLanes(devLanes), .devCount(devCount),
    .devRxValid(devRxValid), .devRxReady(devRxReady),
    .devTxValid(devTxValid), .devTxReady(devTxReady)
  );

  pcd_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_W(WORD_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .startAddr(startAddr), .xferCount(xferCount),
    .devRxData(devRxData), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .devTxData(devTxData),
    .flags(flags)
  );

  // R7
  mem_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady && !(regWe && regAddr == OFF_CTRL))
      |=> ($stable(memAddr) && $stable(memWdata)));
endmodule

// File: tb/tb_page_cache_dma.sv
module tb_page_cache_dma;
  import pcd_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq, memValid, memWe, memReady = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic        devStart, devRead, devRxValid = 1'b0, devRxReady, devTxValid, devTxReady = 1'b0;
  logic [7:0]  devOpcode, devRxData = '0, devTxData;
  logic [1:0]  devLanes;
  logic [12:0] devCount;

  page_cache_dma dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .memValid(memValid), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .devStart(devStart), .devRead(devRead), .devOpcode(devOpcode), .devLanes(devLanes),
    .devCount(devCount), .devRxValid(devRxValid), .devRxData(devRxData),
    .devRxReady(devRxReady), .devTxValid(devTxValid), .devTxData(devTxData),
    .devTxReady(devTxReady)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // models
  logic [31:0] mem [128];
  logic [7:0]  txBuf [256];
  int rxIdx = 0, rxTotal = 0, rxSeed = 0, txIdx = 0;
  int memWrites = 0, cmdCount = 0;
  logic rxHold = 1'b0;
  logic [7:0]  cmdOp;
  logic [1:0]  cmdLanes;
  logic [12:0] cmdCnt;
  logic        cmdRead;

  function automatic logic [7:0] rxByte(int s, int i);
    return (8'h5A ^ 8'(i)) + 8'(s * 7);
  endfunction

  function automatic logic [31:0] memPat(int k, int s);
    return 32'h11223344 + 32'(k) * 32'h01010101 + 32'(s);
  endfunction

  always @(negedge clk) begin
    memReady = memValid && (cyc[0] || cyc[2]);
    if (memValid && memReady) begin
      if (memWe) begin mem[memAddr[8:2]] = memWdata; memWrites++; end
      else memRdata = mem[memAddr[8:2]];
    end
    devRxValid = !rxHold && (rxIdx < rxTotal) && (cyc % 3 != 0);
    devRxData  = rxByte(rxSeed, rxIdx);
    if (devRxValid && devRxReady) rxIdx++;
    devTxReady = cyc[1] || cyc[0];
    if (devTxValid && devTxReady) begin txBuf[txIdx[7:0]] = devTxData; txIdx++; end
    if (devStart) begin
      cmdCount++; cmdOp = devOpcode; cmdLanes = devLanes; cmdCnt = devCount; cmdRead = devRead;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic waitBit(input logic [3:0] a, input int b, output bit ok);
    logic [31:0] d;
    ok = 1'b0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      regRead(a, d);
      ok = d[b];
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {read, count[13], lane[3], opcode[8], expLanes[2], start[13]}
  localparam logic [39:0] VECS [8] = '{
    {1'b1, 13'd8,  3'd0, 8'h03, 2'd0, 13'h100},
    {1'b1, 13'd7,  3'd1, 8'h3B, 2'd1, 13'h040},
    {1'b1, 13'd13, 3'd2, 8'h6B, 2'd2, 13'h082},
    {1'b1, 13'd1,  3'd5, 8'h0B, 2'd0, 13'h000},
    {1'b0, 13'd8,  3'd0, 8'h02, 2'd0, 13'h100},
    {1'b0, 13'd6,  3'd2, 8'h32, 2'd2, 13'h046},
    {1'b0, 13'd5,  3'd1, 8'h84, 2'd0, 13'h0C0},
    {1'b0, 13'd64, 3'd2, 8'h34, 2'd2, 13'h000}
  };

  task automatic setupXfer(input bit isRd, input int cnt, input logic [2:0] lane,
                           input logic [7:0] op, input logic [31:0] sa);
    regWrite(OFF_START, sa);
    regWrite(OFF_COUNT, isRd ? ((32'd3 << 16) | 32'(cnt)) : ((32'(cnt) << 16) | 32'd5));
    regWrite(OFF_LANE, 32'(lane) << 16);
    regWrite(OFF_RDOP, isRd ? 32'(op) : 32'hEE);
    regWrite(OFF_PGOP, (isRd ? 32'h77 : 32'(op)) << 8);
    regWrite(OFF_INTEN, 32'h40);
    regWrite(OFF_CFG, isRd ? 32'h6003 : 32'h3001);
    regWrite(OFF_CTRL, 32'h0);
    rxIdx = 0; rxTotal = cnt; txIdx = 0; cmdCount = 0;
  endtask

  task automatic runVec(input int v, input logic [39:0] e);
    bit isRd; int cnt; logic [2:0] lane; logic [7:0] op; logic [1:0] expL;
    logic [31:0] sa, d; int baseW, nw, bad; bit ok;
    logic [31:0] expW, gotW;
    isRd = e[39]; cnt = int'(e[38:26]); lane = e[25:23]; op = e[22:15];
    expL = e[14:13]; sa = {19'd0, e[12:0]}; baseW = int'(sa[8:2]);
    nw = (cnt + 3) / 4;
    for (int k = 0; k < 128; k++) mem[k] = isRd ? 32'hDEADBEEF : memPat(k, v);
    rxSeed = v;
    setupXfer(isRd, cnt, lane, op, sa);
    regWrite(OFF_CTRL, isRd ? 32'h100 : 32'h200);
    waitBit(OFF_STATUS, isRd ? 25 : 26, ok);
    check(ok, "R8 done bit", 32'(ok), 1);
    check(cmdCount == 1 && cmdRead == isRd, "R3 one command", 32'(cmdCount), 1);
    check(cmdOp == op, "R3 opcode", 32'(cmdOp), 32'(op));
    check(int'(cmdCnt) == cnt, "R3 count", 32'(cmdCnt), 32'(cnt));
    check(cmdLanes == expL, "R4 lanes", 32'(cmdLanes), 32'(expL));
    bad = 0; gotW = '0; expW = '0;
    if (isRd) begin
      for (int k = 0; k < nw; k++) begin
        logic [31:0] w;
        for (int j = 0; j < 4; j++)
          w[j*8 +: 8] = (k*4 + j < cnt) ? rxByte(v, k*4 + j) : 8'h00;
        if (mem[(baseW + k) % 128] !== w && bad == 0) begin
          bad = 1; gotW = mem[(baseW + k) % 128]; expW = w;
        end
      end
      check(bad == 0, "R5 packed words", gotW, expW);
      check(mem[(baseW + nw) % 128] == 32'hDEADBEEF, "R5 no write past end",
            mem[(baseW + nw) % 128], 32'hDEADBEEF);
    end else begin
      check(txIdx == cnt, "R6 byte total", 32'(txIdx), 32'(cnt));
      for (int i = 0; i < cnt; i++) begin
        logic [31:0] w;
        w = memPat((baseW + i/4) % 128, v);
        if (txBuf[i] !== w[(i%4)*8 +: 8] && bad == 0) begin
          bad = 1; gotW = 32'(txBuf[i]); expW = 32'(w[(i%4)*8 +: 8]);
        end
      end
      check(bad == 0, "R6 byte order", gotW, expW);
    end
    regRead(OFF_INTST, d);
    check(d[6], "R8 memory done flag", d, 32'h40);
    check(irq, "R10 irq raised", 32'(irq), 1);
    idle(20);
    check(cmdCount == 1, "R11 held trigger no restart", 32'(cmdCount), 1);
    regWrite(OFF_STATUS, 32'h0600_0000);
    regWrite(OFF_INTST, 32'h40);
    regRead(OFF_STATUS, d);
    check(d == 0, "R9 status cleared", d, 0);
    check(!irq, "R9 R10 irq cleared", 32'(irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d; bit ok; int w0;
    idle(4);
    #1;
    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      regRead(4'(a), d);
      check(d == 0, "R1 register reset", d, 0);
    end
    check(!irq && !memValid && !devRxReady && !devTxValid && !devStart, "R1 outputs idle",
          {27'd0, irq, memValid, devRxReady, devTxValid, devStart}, 0);
    rstN = 1'b1;
    idle(2);

    for (int v = 0; v < 8; v++) runVec(v, VECS[v]);

    // R2 gating: wrong config blocks start
    setupXfer(1'b1, 4, 3'd0, 8'h03, 32'h0);
    regWrite(OFF_CFG, 32'h6002);            // DMA disabled
    regWrite(OFF_CTRL, 32'h100); idle(20);
    check(cmdCount == 0, "R2 dma disabled", 32'(cmdCount), 0);
    regWrite(OFF_CFG, 32'h3003); regWrite(OFF_CTRL, 32'h0);
    regWrite(OFF_CTRL, 32'h100); idle(20);  // wrong op mode
    check(cmdCount == 0, "R2 mode mismatch", 32'(cmdCount), 0);
    regWrite(OFF_CFG, 32'h6003); regWrite(OFF_CTRL, 32'h0);
    regWrite(OFF_CTRL, 32'h200); idle(20);  // write trigger, read config
    check(cmdCount == 0, "R2 direction mismatch", 32'(cmdCount), 0);

    // R11 edge while busy
    rxHold = 1'b1;
    regWrite(OFF_CTRL, 32'h0); regWrite(OFF_CTRL, 32'h100); idle(5);
    check(cmdCount == 1 && devRxReady, "R11 transfer parked", 32'(cmdCount), 1);
    regWrite(OFF_CTRL, 32'h0); regWrite(OFF_CTRL, 32'h100); idle(5);
    rxHold = 1'b0;
    waitBit(OFF_STATUS, 25, ok);
    idle(20);
    check(ok && cmdCount == 1, "R11 busy edge ignored", 32'(cmdCount), 1);

    // R9 writing zero leaves flags set
    regWrite(OFF_STATUS, 32'h0); regWrite(OFF_INTST, 32'h0);
    regRead(OFF_STATUS, d);
    check(d == 32'h0200_0000, "R9 zero write keeps status", d, 32'h0200_0000);
    regRead(OFF_INTST, d);
    check(d == 32'h40, "R9 zero write keeps int flag", d, 32'h40);

    // R10 enable gating
    regWrite(OFF_INTEN, 32'h0);
    check(!irq, "R10 irq masked", 32'(irq), 0);
    regWrite(OFF_INTEN, 32'h40);
    check(irq, "R10 irq unmasked", 32'(irq), 1);
    regWrite(OFF_STATUS, 32'h0600_0000); regWrite(OFF_INTST, 32'h40);

    // R12 abort mid-transfer
    setupXfer(1'b1, 8, 3'd0, 8'h03, 32'h0);
    rxHold = 1'b1; w0 = memWrites;
    regWrite(OFF_CTRL, 32'h100); idle(5);
    regWrite(OFF_CTRL, 32'h2); idle(2);
    check(!devRxReady && !memValid, "R12 engine idle after reset bit",
          {30'd0, devRxReady, memValid}, 0);
    rxHold = 1'b0; idle(30);
    regRead(OFF_STATUS, d);
    check(d == 0 && memWrites == w0, "R12 no done after abort", d, 0);
    regRead(OFF_CTRL, d);
    check(d == 0, "R12 flush/reset bits read zero", d, 0);
    regWrite(OFF_CTRL, 32'h1);
    regRead(OFF_CTRL, d);
    check(d == 0, "R12 flush bit reads zero", d, 0);
    rxIdx = 0; cmdCount = 0;
    regWrite(OFF_CTRL, 32'h100);
    waitBit(OFF_STATUS, 25, ok);
    check(ok && cmdCount == 1, "R12 restart after abort", 32'(cmdCount), 1);
    regWrite(OFF_STATUS, 32'h0600_0000); regWrite(OFF_INTST, 32'h40);

    // R13 zero count
    setupXfer(1'b1, 0, 3'd0, 8'h03, 32'h0);
    w0 = memWrites;
    regWrite(OFF_CTRL, 32'h100);
    waitBit(OFF_STATUS, 25, ok);
    check(ok && cmdCount == 1 && cmdCnt == 0, "R13 zero count command", 32'(cmdCnt), 0);
    check(memWrites == w0, "R13 no memory access", 32'(memWrites - w0), 0);
    regRead(OFF_INTST, d);
    check(d[6], "R13 memory done set", d, 32'h40);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule